// File: doc/BRIEF.md
# Four-Peak Exclusion Searcher

This block takes a complex channel estimate of DEPTH entries (192 by default, three samples per chip) and picks the four strongest echoes for a four-finger combiner. The estimate arrives as a stream of signed I/Q samples and is held in an internal buffer. When the buffer is full, the search starts on its own. It makes four full passes over the buffer, one entry per clock. Each pass finds the entry with the largest approximate magnitude |I| + |Q|. The block records that entry, then removes the winner and every position within two samples of it from all later passes. Any two chosen echoes are therefore at least one chip apart.

The ranking uses a compare threshold. A pass whose winner does not exceed the threshold yields an empty slot. The four slots are published together in a single clock and marked by a one-cycle completion pulse. A combiner reading the outputs therefore never sees a mix of old and new results. Samples that arrive while a search is running are dropped.

Top module: `echo_peak_picker`

## Requirements
- R1: Samples presented with `sampleValid` high while the block is idle are written to buffer positions 0, 1, 2, … in arrival order. Accepting the sample for position DEPTH-1 starts the search without any further input.
- R2: Magnitude is |I| + |Q|, with I and Q in two's complement. Slot 0 holds the strongest entry, and each later slot holds an entry no stronger than the one before it. A slot k occupies bits [k*W +: W] of each flat output port.
- R3: When two eligible entries have equal magnitude, the one at the lower buffer position wins.
- R4: After pass winner p, positions p-2 through p+2 are barred from every later pass. There is no wrap-around: position 0 does not bar position DEPTH-1, and the reverse also holds. Any two valid slots therefore differ in position by at least 3.
- R5: A slot is valid only when its winner's magnitude is strictly greater than `threshold`. An empty slot reports position 0, I = 0, Q = 0 and a valid bit of 0.
- R6: `found` equals the valid bit of slot 0.
- R7: All result ports change together, in the same clock edge that raises `done`. `done` is high for exactly one cycle. Between those edges the result ports hold their values.
- R8: Samples presented while a search is running are ignored. The next load after `done` starts again at position 0.
- R9: After reset, `done`, `found`, every valid bit, every position and every coefficient are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Qualifies an estimate sample |
| sampleI | input | SAMPLE_W | In-phase part of the sample, signed |
| sampleQ | input | SAMPLE_W | Quadrature part of the sample, signed |
| threshold | input | SAMPLE_W+1 | A slot is valid only above this magnitude |
| peakIdx | output | 4*IDX_W | Buffer position of each slot |
| peakI | output | 4*SAMPLE_W | In-phase coefficient of each slot |
| peakQ | output | 4*SAMPLE_W | Quadrature coefficient of each slot |
| peakValid | output | 4 | Per-slot valid bit |
| found | output | 1 | Slot 0 holds an echo above the threshold |
| done | output | 1 | One-cycle pulse when new results appear |

## Verification
The scan is tried with these patterns:
- A lone echo in an empty estimate, which shows that one pass works and that empty slots come out zeroed.
- Four well-spaced echoes of falling strength, which confirms the ordering.
- Entries with negative components, which separates |I| + |Q| from a signed comparison.
- Two equal-magnitude echoes, which exposes the tie rule.
- A cluster of echoes spaced one and two samples apart, together with echoes at both ends of the buffer. This distinguishes a correct ±2 exclusion from a narrower or wrapping one.
- Threshold cases where only some echoes, or none, clear the limit.
- A pseudo-random full estimate.
- A run with garbage samples fed during the search, which shows that the buffer stays frozen and the outputs do not move before the completion pulse.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int NUM_PEAKS = 4;
  localparam int PASS_W = $clog2(NUM_PEAKS);

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic wrEn;      // write sample at addr
    logic startEn;   // clear exclusion vector and running best
    logic scanEn;    // compare entry at addr with running best
    logic markEn;    // stage pass winner and bar its neighbourhood
    logic commitEn;  // copy staged slots to outputs
    logic [PASS_W-1:0] pass;
  } ctlStrobes_t;
endpackage

// File: rtl/epp_ctrl.sv
module epp_ctrl
  import epp_pkg::*;
#(
  parameter int DEPTH = 192,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  output ctlStrobes_t      ctl,
  output logic [IDX_W-1:0] addr,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(DEPTH - 1);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PEAKS - 1);

  typedef enum logic [1:0] {LOAD, SCAN, MARK, PUBLISH} state_t;

  state_t            state;
  logic [IDX_W-1:0]  cnt;
  logic [PASS_W-1:0] passCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= LOAD;
      cnt     <= '0;
      passCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == PUBLISH);
      unique case (state)
        LOAD: if (sampleValid) begin
          if (cnt == LAST_POS) begin
            cnt     <= '0;
            passCnt <= '0;
            state   <= SCAN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SCAN: begin
          if (cnt == LAST_POS) begin
            cnt   <= '0;
            state <= MARK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        MARK: begin
          if (passCnt == LAST_PASS) begin
            state <= PUBLISH;
          end else begin
            passCnt <= passCnt + 1'b1;
            state   <= SCAN;
          end
        end
        PUBLISH: state <= LOAD;
        default: state <= LOAD;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.pass     = passCnt;
    ctl.wrEn     = (state == LOAD) && sampleValid;
    ctl.startEn  = (state == LOAD) && sampleValid && (cnt == LAST_POS);
    ctl.scanEn   = (state == SCAN);
    ctl.markEn   = (state == MARK);
    ctl.commitEn = (state == PUBLISH);
    addr         = cnt;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  commit_after_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitEn |-> $past(ctl.markEn));

  // R8
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.scanEn || ctl.markEn) |=> !ctl.wrEn || !$past(ctl.markEn && (passCnt != LAST_PASS)));
endmodule

// File: rtl/epp_datapath.sv
module epp_datapath
  import epp_pkg::*;
#(
  parameter int DEPTH = 192,
  parameter int SAMPLE_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int MAG_W = SAMPLE_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   ctl,
  input  logic [IDX_W-1:0]              addr,
  input  logic signed [SAMPLE_W-1:0]    sampleI,
  input  logic signed [SAMPLE_W-1:0]    sampleQ,
  input  logic [MAG_W-1:0]              threshold,
  output logic [NUM_PEAKS*IDX_W-1:0]    peakIdx,
  output logic [NUM_PEAKS*SAMPLE_W-1:0] peakI,
  output logic [NUM_PEAKS*SAMPLE_W-1:0] peakQ,
  output logic [NUM_PEAKS-1:0]          peakValid,
  output logic                          found
);
  function automatic logic [MAG_W-1:0] magOf(input logic signed [SAMPLE_W-1:0] i,
                                             input logic signed [SAMPLE_W-1:0] q);
    logic signed [SAMPLE_W:0] ei;
    logic signed [SAMPLE_W:0] eq;
    ei = i;
    eq = q;
    if (ei < 0) ei = -ei;
    if (eq < 0) eq = -eq;
    return $unsigned(ei) + $unsigned(eq);
  endfunction

  logic signed [SAMPLE_W-1:0] memI [DEPTH];
  logic signed [SAMPLE_W-1:0] memQ [DEPTH];
  logic [DEPTH-1:0]           barred;

  logic [MAG_W-1:0]           bestMag;
  logic [IDX_W-1:0]           bestIdx;
  logic signed [SAMPLE_W-1:0] bestI, bestQ;

  logic [IDX_W-1:0]           stIdx [NUM_PEAKS];
  logic signed [SAMPLE_W-1:0] stI   [NUM_PEAKS];
  logic signed [SAMPLE_W-1:0] stQ   [NUM_PEAKS];
  logic [NUM_PEAKS-1:0]       stValid;

  logic [MAG_W-1:0]           curMag;
  logic                       winHit;

  // estimate buffer
  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      memI[addr] <= sampleI;
      memQ[addr] <= sampleQ;
    end
  end

  always_comb begin
    curMag = barred[addr] ? '0 : magOf(memI[addr], memQ[addr]);
    winHit = bestMag > threshold;
  end

  // running best, exclusion vector and per-pass staging
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      barred  <= '0;
      bestMag <= '0;
      bestIdx <= '0;
      bestI   <= '0;
      bestQ   <= '0;
      stValid <= '0;
      for (int k = 0; k < NUM_PEAKS; k++) begin
        stIdx[k] <= '0;
        stI[k]   <= '0;
        stQ[k]   <= '0;
      end
    end else if (ctl.startEn) begin
      barred  <= '0;
      bestMag <= '0;
      bestIdx <= '0;
      bestI   <= '0;
      bestQ   <= '0;
    end else if (ctl.scanEn) begin
      if (curMag > bestMag) begin
        bestMag <= curMag;
        bestIdx <= addr;
        bestI   <= memI[addr];
        bestQ   <= memQ[addr];
      end
    end else if (ctl.markEn) begin
      stValid[ctl.pass] <= winHit;
      stIdx[ctl.pass]   <= winHit ? bestIdx : '0;
      stI[ctl.pass]     <= winHit ? bestI : '0;
      stQ[ctl.pass]     <= winHit ? bestQ : '0;
      for (int j = 0; j < DEPTH; j++) begin
        if ((j + 2 >= int'(bestIdx)) && (j <= int'(bestIdx) + 2)) barred[j] <= 1'b1;
      end
      bestMag <= '0;
      bestIdx <= '0;
      bestI   <= '0;
      bestQ   <= '0;
    end
  end

  // result registers, all slots in one edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peakIdx   <= '0;
      peakI     <= '0;
      peakQ     <= '0;
      peakValid <= '0;
      found     <= 1'b0;
    end else if (ctl.commitEn) begin
      for (int k = 0; k < NUM_PEAKS; k++) begin
        peakIdx[k*IDX_W +: IDX_W]       <= stIdx[k];
        peakI[k*SAMPLE_W +: SAMPLE_W]   <= stI[k];
        peakQ[k*SAMPLE_W +: SAMPLE_W]   <= stQ[k];
      end
      peakValid <= stValid;
      found     <= stValid[0];
    end
  end

  // R7
  hold_results_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commitEn |=> $stable({peakIdx, peakI, peakQ, peakValid, found}));

  // R6
  found_slot0_chk: assert property (@(posedge clk) disable iff (!rstN)
    found == peakValid[0]);

  always @(posedge clk) begin
    if (rstN) begin
      for (int a = 0; a < NUM_PEAKS; a++) begin
        for (int b = a + 1; b < NUM_PEAKS; b++) begin
          if (peakValid[a] && peakValid[b]) begin
            // R4
            spacing_chk: assert ((int'(peakIdx[a*IDX_W +: IDX_W]) - int'(peakIdx[b*IDX_W +: IDX_W]) >= 3) ||
                                 (int'(peakIdx[b*IDX_W +: IDX_W]) - int'(peakIdx[a*IDX_W +: IDX_W]) >= 3));
          end
        end
      end
      for (int k = 1; k < NUM_PEAKS; k++) begin
        if (peakValid[k]) begin
          // R2
          order_chk: assert (peakValid[k-1] &&
            (magOf(peakI[(k-1)*SAMPLE_W +: SAMPLE_W], peakQ[(k-1)*SAMPLE_W +: SAMPLE_W]) >=
             magOf(peakI[k*SAMPLE_W +: SAMPLE_W], peakQ[k*SAMPLE_W +: SAMPLE_W])));
        end
      end
    end
  end
endmodule

// File: rtl/echo_peak_picker.sv
module echo_peak_picker
  import epp_pkg::*;
#(
  parameter int DEPTH = 192,
  parameter int SAMPLE_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int MAG_W = SAMPLE_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sampleValid,
  input  logic signed [SAMPLE_W-1:0]    sampleI,
  input  logic signed [SAMPLE_W-1:0]    sampleQ,
  input  logic [MAG_W-1:0]              threshold,
  output logic [NUM_PEAKS*IDX_W-1:0]    peakIdx,
  output logic [NUM_PEAKS*SAMPLE_W-1:0] peakI,
  output logic [NUM_PEAKS*SAMPLE_W-1:0] peakQ,
  output logic [NUM_PEAKS-1:0]          peakValid,
  output logic                          found,
  output logic                          done
);
  ctlStrobes_t      ctl;
  logic [IDX_W-1:0] addr;

  epp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .ctl         (ctl),
    .addr        (addr),
    .done        (done)
  );

  epp_datapath #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .addr      (addr),
    .sampleI   (sampleI),
    .sampleQ   (sampleQ),
    .threshold (threshold),
    .peakIdx   (peakIdx),
    .peakI     (peakI),
    .peakQ     (peakQ),
    .peakValid (peakValid),
    .found     (found)
  );
endmodule

// File: tb/echo_peak_picker_test.sv
module echo_peak_picker_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 192;
  localparam int W = 8;
  localparam int IW = $clog2(DEPTH);
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [W-1:0] sampleI = '0;
  logic signed [W-1:0] sampleQ = '0;
  logic [W:0] threshold = '0;
  logic [NP*IW-1:0] peakIdx;
  logic [NP*W-1:0] peakI, peakQ;
  logic [NP-1:0] peakValid;
  logic found, done;

  int errors = 0;
  int checks = 0;

  int estI [DEPTH];
  int estQ [DEPTH];
  int expIdx [NP];
  int expI [NP];
  int expQ [NP];
  bit expValid [NP];
  bit expFound;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  echo_peak_picker #(.DEPTH(DEPTH), .SAMPLE_W(W)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleI(sampleI),
    .sampleQ(sampleQ), .threshold(threshold), .peakIdx(peakIdx), .peakI(peakI),
    .peakQ(peakQ), .peakValid(peakValid), .found(found), .done(done));

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic clearEst();
    for (int j = 0; j < DEPTH; j++) begin estI[j] = 0; estQ[j] = 0; end
  endtask

  task automatic nextRand(output int v);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    v = int'($signed(lfsr[7:0]));
  endtask

  // expected slots from the requirements (R2..R6)
  task automatic computeExpected(input int thr);
    bit bar [DEPTH];
    for (int j = 0; j < DEPTH; j++) bar[j] = 0;
    for (int p = 0; p < NP; p++) begin
      int bm = 0;
      int bi = 0;
      for (int j = 0; j < DEPTH; j++) begin
        int m = bar[j] ? 0 : absv(estI[j]) + absv(estQ[j]);
        if (m > bm) begin bm = m; bi = j; end
      end
      expValid[p] = (bm > thr);
      expIdx[p] = expValid[p] ? bi : 0;
      expI[p] = expValid[p] ? estI[bi] : 0;
      expQ[p] = expValid[p] ? estQ[bi] : 0;
      for (int j = bi - 2; j <= bi + 2; j++) if (j >= 0 && j < DEPTH) bar[j] = 1;
    end
    expFound = expValid[0];
  endtask

  task automatic checkSlots(input string tag);
    for (int k = 0; k < NP; k++) begin
      int gi = int'(peakIdx[k*IW +: IW]);
      int gI = int'($signed(peakI[k*W +: W]));
      int gQ = int'($signed(peakQ[k*W +: W]));
      checks++;
      if (gi != expIdx[k] || gI != expI[k] || gQ != expQ[k] || peakValid[k] != expValid[k]) begin
        errors++;
        $display("FAIL %s slot%0d: got idx=%0d I=%0d Q=%0d v=%0b, expected idx=%0d I=%0d Q=%0d v=%0b",
                 tag, k, gi, gI, gQ, peakValid[k], expIdx[k], expI[k], expQ[k], expValid[k]);
      end
    end
    checks++;
    if (found != expFound) begin
      errors++;
      $display("FAIL %s R6 found: got %0b expected %0b", tag, found, expFound);
    end
  endtask

  task automatic loadEst(input int garbage, input string tag);
    for (int j = 0; j < DEPTH; j++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleI = W'(estI[j]);
      sampleQ = W'(estQ[j]);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    for (int g = 0; g < garbage; g++) begin
      int v;
      sampleValid = 1'b1;
      nextRand(v); sampleI = W'(v);
      nextRand(v); sampleQ = W'(v);
      if (g == garbage / 2) checkSlots({tag, " R7 hold during search"});
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s R1 done: got 0 expected 1 (search never completed)", tag);
    end
  endtask

  task automatic runCase(input string tag, input int thr, input int garbage);
    threshold = (W+1)'(thr);
    loadEst(garbage, tag);
    computeExpected(thr);
    waitDone(tag);
    checkSlots(tag);
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL %s R7 done width: got %0b expected 0", tag, done);
    end
  endtask

  task automatic testReset();
    checks++;
    if (done !== 1'b0 || found !== 1'b0 || peakValid !== '0 || peakIdx !== '0 ||
        peakI !== '0 || peakQ !== '0) begin
      errors++;
      $display("FAIL R9 reset: got done=%0b found=%0b valid=%b idx=%h, expected all 0",
               done, found, peakValid, peakIdx);
    end
  endtask

  task automatic testSingle();  // R1, R5
    clearEst(); estI[50] = 30; estQ[50] = -12;
    runCase("R1 single echo", 0, 0);
  endtask

  task automatic testOrdered();  // R2
    clearEst();
    estI[40] = 70; estI[10] = 90; estQ[180] = 30; estI[120] = -50;
    runCase("R2 ordered echoes", 0, 0);
  endtask

  task automatic testNegative();  // R2 magnitude |I|+|Q|
    clearEst();
    estI[5] = -40; estQ[5] = -30; estI[9] = 60; estQ[70] = -127; estI[140] = -128;
    runCase("R2 negative parts", 0, 0);
  endtask

  task automatic testTie();  // R3
    clearEst();
    estI[60] = -20; estQ[60] = -10; estI[20] = 10; estQ[20] = 20;
    estI[150] = 15; estI[100] = 15;
    runCase("R3 tie lower index", 0, 0);
  endtask

  task automatic testCluster();  // R4
    clearEst();
    estI[100] = 100; estI[102] = 90; estI[98] = 85; estI[103] = 80; estI[97] = 20;
    runCase("R4 neighbour exclusion", 0, 0);
  endtask

  task automatic testEdges();  // R4 no wrap
    clearEst();
    estI[0] = 80; estI[1] = 70; estI[2] = 60; estI[3] = 50;
    estI[191] = 75; estI[189] = 74; estI[188] = 40;
    runCase("R4 buffer ends", 0, 0);
  endtask

  task automatic testThreshold();  // R5, R6
    clearEst();
    estI[10] = 100; estI[50] = 60; estI[90] = 40; estI[130] = 20;
    runCase("R5 partial threshold", 55, 0);
    runCase("R6 nothing above threshold", 200, 0);
    runCase("R5 threshold equal not valid", 60, 0);
  endtask

  task automatic testRandom();  // R2, R4
    for (int j = 0; j < DEPTH; j++) begin
      int v;
      nextRand(v); estI[j] = v;
      nextRand(v); estQ[j] = v;
    end
    runCase("R2 random estimate", 30, 0);
  endtask

  task automatic testBusy();  // R7, R8
    for (int j = 0; j < DEPTH; j++) begin
      estI[j] = (j % 7) - 3; estQ[j] = 0;
    end
    estI[33] = 55; estQ[77] = -66; estI[150] = 44; estI[151] = 43;
    runCase("R8 ignore during search", 5, 300);
    clearEst(); estI[2] = 9; estQ[190] = 8;
    runCase("R8 reload from position 0", 0, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testOrdered();
    testNegative();
    testTie();
    testCluster();
    testEdges();
    testThreshold();
    testRandom();
    testBusy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule